// File: doc/BRIEF.md
# Periodic Timer with Prescaler and Postscaler

An 8-bit up-counter with a programmable period. It advances on a qualified tick enable that runs at instruction rate. An input prescaler divides the tick by 1, 4 or 16. The counter climbs from zero until it equals the period value, and the next advance returns it to zero instead of incrementing. Each such wrap is a match event.

Every match is exported as a one-cycle strobe, taken before the postscaler, for use as a serial shift-clock source. Match events also feed a 4-bit postscaler. Each time the postscaler completes a cycle, it sets a sticky interrupt flag.

Software reaches the counter, the period and a control byte through a small register bus. Writes are single-cycle and reads are combinational. A separate input clears the flag. Writing the counter or the control byte restarts both scalers. A control write never disturbs the count.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 00h, the period reads FFh, the control byte reads 00h, and both irq_o and match_o are low.
- R2: Address 0 selects the counter, address 1 the period and address 2 the control byte. rdata_o follows addr_i in the same cycle. Control bit 7 reads as 0, and an unused address reads 0.
- R3: Control bits 1:0 select the prescale ratio: 00 divides by 1, 01 by 4, and 10 or 11 by 16. The counter advances once per that many qualified ticks.
- R4: The counter rises from 00h to the period value, and the advance after equality loads 00h. A count above the period runs up through FFh to 00h without producing a match.
- R5: match_o is high for exactly the one cycle after a wrapping advance. With a steady tick, matches are spaced ratio × (period + 1) cycles apart.
- R6: The postscale value N in control bits 6:3 sets irq_o on every (N+1)-th match, in the same cycle as that match pulse.
- R7: While control bit 2 (run) is 0, or tick_i is low, the counter and both scalers hold.
- R8: A counter write loads wdata_i, clears both scalers and overrides any advance in that cycle.
- R9: A control write clears both scalers and leaves the counter value unchanged.
- R10: irq_o stays set until irq_clr_i is applied. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count tick enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| match_o | output | 1 | Pre-postscaler match strobe |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that addr_i and wdata_i are meaningful only while wr_en_i is high. They also assume that the counter is loaded only through a counter write, so any hold or load property can key off wr_en_i and addr_i alone. The stimulus changes inputs only at the falling edge and issues one write per cycle. It keeps irq_clr_i low during the sweep, except for a deliberate overlap test where clear and set coincide.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W   = 2;
  localparam int POST_W   = 4;
  localparam int PRE_SEL_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT  = 2'd0,
    REG_PER  = 2'd1,
    REG_CTRL = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic [POST_W-1:0]    post;
    logic                 run;
    logic [PRE_SEL_W-1:0] pre;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int DIV_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  localparam logic [DIV_W-1:0] MID_TERM = DIV_W'((1 << (DIV_W / 2)) - 1);

  logic [DIV_W-1:0] div_q, term;

  always_comb begin
    case (sel_i)
      2'b00:   term = '0;
      2'b01:   term = MID_TERM;
      default: term = '1;
    endcase
  end

  assign step_o = en_i && (div_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clr_i)   div_q <= '0;
    else if (en_i)    div_q <= step_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == period_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_postscale.sv
module ptmr_postscale #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wrap_i,
  input  logic [W-1:0] sel_i,
  output logic         fire_o
);
  logic [W-1:0] post_q;

  assign fire_o = wrap_i && (post_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      post_q <= '0;
    else if (clr_i)   post_q <= '0;
    else if (wrap_i)  post_q <= fire_o ? '0 : post_q + 1'b1;
  end
endmodule

// File: rtl/period_timer.sv
module period_timer
  import ptmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              irq_clr_i,
  output logic              match_o,
  output logic              irq_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] period_q, cnt_q;
  logic         wr_cnt, wr_per, wr_ctrl, scaler_clr, tick_en;
  logic         step, wrap, fire, match_q, irq_q;

  assign wr_cnt     = wr_en_i && (addr_i == REG_CNT);
  assign wr_per     = wr_en_i && (addr_i == REG_PER);
  assign wr_ctrl    = wr_en_i && (addr_i == REG_CTRL);
  assign scaler_clr = wr_cnt || wr_ctrl;
  // a restarting write swallows the tick of its own cycle
  assign tick_en    = ctrl_q.run && tick_i && !scaler_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_per)  period_q <= wdata_i;
    end
  end

  ptmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (scaler_clr),
    .en_i   (tick_en),
    .sel_i  (ctrl_q.pre),
    .step_o (step)
  );

  ptmr_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i),
    .step_i     (step),
    .period_i   (period_q),
    .cnt_o      (cnt_q),
    .wrap_o     (wrap)
  );

  ptmr_postscale #(.W(POST_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (scaler_clr),
    .wrap_i (wrap),
    .sel_i  (ctrl_q.post),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= wrap;
      if (fire)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      REG_CNT:  rdata_o = cnt_q;
      REG_PER:  rdata_o = period_q;
      REG_CTRL: rdata_o = W'(ctrl_q);
      default:  rdata_o = '0;
    endcase
  end

  assign match_o = match_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic              irq_clr_i,
  input logic              match_o,
  input logic              irq_o,
  input logic [W-1:0]      cnt_i,
  input logic              run_i
);
  AST_MATCH_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (cnt_i == '0)); // R4
  AST_IRQ_WITH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> match_o); // R6
  AST_HALT_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(cnt_i)); // R7
  AST_HALT_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(cnt_i)); // R7
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CNT) |=> (cnt_i == $past(wdata_i))); // R8
  AST_CTRL_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CTRL) |=> $stable(cnt_i)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_clr_i)); // R10
endmodule

bind period_timer ptmr_checker #(.W(W)) u_ptmr_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_clr_i (irq_clr_i),
  .match_o   (match_o),
  .irq_o     (irq_o),
  .cnt_i     (cnt_q),
  .run_i     (ctrl_q.run)
);

// File: tb/period_timer_bench.sv
`timescale 1ns/1ps
module period_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_clr = 1'b0;
  logic       match, irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  period_timer u_period_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_clr_i(irq_clr), .match_o(match), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step_cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  function automatic int ratio_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  task automatic sweep_one(input int sel, input int p, input int n);
    int t, bad_m, bad_i, first_k, act_m, act_i;
    t = ratio_of(sel) * (p + 1);
    bad_m = 0; bad_i = 0; first_k = 0; act_m = 0; act_i = 0;
    wr(2'd2, 8'h00);
    irq_clr = 1'b1; step_cycle(); irq_clr = 1'b0;
    wr(2'd1, 8'(p));
    wr(2'd0, 8'h00);
    wr(2'd2, {1'b0, 4'(n), 1'b1, 2'(sel)});
    for (int k = 1; k <= (n + 2) * t; k++) begin
      step_cycle();
      if (match !== ((k % t) == 0)) begin
        if (bad_m == 0) begin first_k = k; act_m = match; end
        bad_m++;
      end
      if (irq !== (k >= (n + 1) * t)) begin
        if (bad_i == 0) act_i = k;
        bad_i++;
      end
    end
    chk(bad_m == 0, "R3/R5 match spacing", first_k, t);
    chk(bad_i == 0, "R6 postscaled irq", act_i, (n + 1) * t);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); chk(v == 8'h00, "R1 counter", v, 0);
    rd(2'd1, v); chk(v == 8'hFF, "R1 period", v, 255);
    rd(2'd2, v); chk(v == 8'h00, "R1 control", v, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(match == 1'b0, "R1 match", match, 0);

    // R2 access
    wr(2'd1, 8'hA5); rd(2'd1, v); chk(v == 8'hA5, "R2 period readback", v, 165);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk(v == 8'h7F, "R2 control bit7 zero", v, 127);
    rd(2'd3, v); chk(v == 8'h00, "R2 unused address", v, 0);
    wr(2'd0, 8'h3C); rd(2'd0, v); chk(v == 8'h3C, "R8 counter load", v, 60);
    wr(2'd2, 8'h00);

    // R7 tick low holds the count
    wr(2'd1, 8'hFF); wr(2'd0, 8'h00); wr(2'd2, 8'h04);
    repeat (5) step_cycle();
    rd(2'd0, v); chk(v == 8'h00, "R7 tick low hold", v, 0);

    // R9 control write keeps count; R7 run low halts
    tick = 1'b1;
    wr(2'd0, 8'h00); wr(2'd2, 8'h04);
    repeat (5) step_cycle();
    wr(2'd2, 8'h00);
    rd(2'd0, v); chk(v == 8'h05, "R9 count kept on control write", v, 5);
    repeat (10) step_cycle();
    rd(2'd0, v); chk(v == 8'h05, "R7 run low hold", v, 5);

    // R8 counter write restarts the prescaler (1:4)
    wr(2'd0, 8'h00); wr(2'd2, 8'h05);
    repeat (2) step_cycle();
    wr(2'd0, 8'd10);
    ok = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step_cycle();
      rd(2'd0, v);
      if (v != ((k < 4) ? 8'd10 : 8'd11)) ok = 1'b0;
    end
    chk(ok, "R8 prescaler cleared by counter write", v, 11);

    // R9 control write restarts the prescaler (1:4)
    repeat (2) step_cycle();
    wr(2'd2, 8'h05);
    ok = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step_cycle();
      rd(2'd0, v);
      if (v != ((k < 4) ? 8'd11 : 8'd12)) ok = 1'b0;
    end
    chk(ok, "R9 prescaler cleared by control write", v, 12);

    // R4 count above period rolls over without a match
    wr(2'd2, 8'h00); wr(2'd1, 8'd5); wr(2'd0, 8'd250); wr(2'd2, 8'h04);
    ok = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step_cycle();
      if (match !== (k == 12)) ok = 1'b0;
      if (k == 5) begin rd(2'd0, v); chk(v == 8'hFF, "R4 reaches FF", v, 255); end
      if (k == 6) begin rd(2'd0, v); chk(v == 8'h00, "R4 natural rollover", v, 0); end
    end
    chk(ok, "R4/R5 no match above period, match at wrap", match, 1);

    // R5 one-cycle pulse with period > 0
    step_cycle();
    chk(match == 1'b0, "R5 pulse width", match, 0);

    // R10 sticky flag and set-wins overlap
    wr(2'd2, 8'h00);
    irq_clr = 1'b1; step_cycle(); irq_clr = 1'b0;
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd2, 8'h04);
    step_cycle();
    chk(irq == 1'b1, "R10 flag set", irq, 1);
    irq_clr = 1'b1;
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step_cycle();
      if (irq !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R10 set wins over clear", irq, 1);
    irq_clr = 1'b0;
    wr(2'd2, 8'h00);
    repeat (6) step_cycle();
    chk(irq == 1'b1, "R10 flag sticky", irq, 1);
    irq_clr = 1'b1; step_cycle(); irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 flag cleared", irq, 0);

    // R3 R5 R6 sweep
    for (int sel = 0; sel < 4; sel++)
      for (int pi = 0; pi < 3; pi++)
        for (int ni = 0; ni < 3; ni++)
          sweep_one(sel, (pi == 0) ? 0 : (pi == 1) ? 2 : 5,
                    (ni == 0) ? 0 : (ni == 1) ? 1 : 15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule